// File: doc/BRIEF.md
# Banked I/O Window Decoder with Indexed Register Pair

This block produces the chip selects for an add-on card that sits on a legacy 16-bit-address I/O bus. An access counts only while the DMA address-enable line is low and exactly one of the active-low read or write strobes is low. The lower ten address lines pick a 32-port window at 300h, which lies inside the upper 512-address region that add-on cards may use. The range below 200h belongs to devices on the main board.

In the banked variant, address lines 13..10 name one of 16 banks. Each bank is an alias of the same 32-port window, so separate pieces of card hardware can share the low window. Lines 15..14 must be zero for a match. Bank 0 is the plain 300h..31Fh range. The decoder returns a one-hot bank select, the port offset inside the window, and qualified read and write strobes, all combinational from the bus inputs.

Bank 0 also holds an index/data pair. Offset 0 is a 3-bit index register that can be written and read back. Offset 1 reaches whichever of eight external registers the index selects, through one-hot read and write strobes. The index register is the only clocked state in the block.

Top module: `legacy_io_decoder`

## Requirements
- R1: `rd_stb` is high exactly when `aen` is 0, `ior_n` is 0, `iow_n` is 1 and the address hits the window. `wr_stb` is high exactly when `aen` is 0, `iow_n` is 0, `ior_n` is 1 and the address hits. With `aen` at 1, every select and strobe output is 0.
- R2: The address hits the window when addr[9:5] equals 5'b11000 (300h..31Fh). `port_off` always equals addr[4:0].
- R3: Bit addr[13:10] of `bank_sel` is the only bit set during a qualified cycle that hits, and only when addr[15:14] is 2'b00. In every other case `bank_sel` is all zero.
- R4: When `ior_n` and `iow_n` are both 0, the block treats the cycle as invalid. Every strobe and select is then 0.
- R5: After reset, `idx_q` is 0.
- R6: A qualified write to bank 0, offset 0 loads `idx_wdata` into `idx_q` at the rising clock edge. Any other write leaves `idx_q` unchanged, as do reads and cycles with `aen` high.
- R7: `idx_oe` is high only during a qualified read of bank 0, offset 0. `idx_q` carries the index value at that time.
- R8: A qualified read of bank 0, offset 1 sets only bit `idx_q` of `reg_rd`. A qualified write there sets only bit `idx_q` of `reg_wr`. Otherwise both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the index register |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | I/O address lines |
| aen | input | 1 | DMA address enable; 1 blocks decoding |
| ior_n | input | 1 | Active-low I/O read strobe |
| iow_n | input | 1 | Active-low I/O write strobe |
| idx_wdata | input | 3 | Low data lines loaded into the index |
| bank_sel | output | 16 | One-hot bank select |
| port_off | output | 5 | Port offset inside the window |
| rd_stb | output | 1 | Qualified read strobe |
| wr_stb | output | 1 | Qualified write strobe |
| idx_oe | output | 1 | Drive index onto the data bus |
| idx_q | output | 3 | Current index value |
| reg_rd | output | 8 | One-hot read strobe of the indexed register |
| reg_wr | output | 8 | One-hot write strobe of the indexed register |

## Verification
The hardest case to reach is a write strobe sweeping across the address space while the index register is live. Every write that lands on offset 0 reloads the index, which would shift the expected indexed strobes in the middle of the sweep. To avoid that, the stimulus first loads a known index and holds `idx_wdata` at that same value during the full 64K-address read and write sweep. Reloads then leave the value unchanged, and the expected data-port strobe stays fixed. Separate directed writes to aliased banks, with `aen` high, and reads at offset 0 show that the index moves only on the one legal write.

// File: rtl/iodec_pkg.sv
package iodec_pkg;
   localparam int unsigned DEC_LINES = 10;

   typedef struct packed {
      logic rd;
      logic wr;
   } iodec_cyc_t;

   function automatic logic in_card_space(input int unsigned base, input int unsigned win_bits);
      return (base >= 32'h200) && (base + (32'd1 << win_bits) <= 32'h400);
   endfunction
endpackage

// File: rtl/iodec_cycle_qual.sv
module iodec_cycle_qual
   import iodec_pkg::*;
(
   input  logic       aen,
   input  logic       ior_n,
   input  logic       iow_n,
   output iodec_cyc_t cyc
);
   always_comb begin
      cyc.rd = !aen && !ior_n && iow_n;
      cyc.wr = !aen && !iow_n && ior_n;
   end

   always_comb begin
      assert_one_dir_R4: assert (!(cyc.rd && cyc.wr));
   end
endmodule

// File: rtl/iodec_window.sv
module iodec_window
   import iodec_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned BASE      = 32'h300,
   parameter int unsigned WIN_BITS  = 5,
   parameter int unsigned BANK_BITS = 4,
   parameter bit          BANKED    = 1'b1
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic                 hit,
   output logic [BANK_BITS-1:0] bank,
   output logic [WIN_BITS-1:0]  off
);
   localparam int unsigned UP_LO = DEC_LINES + BANK_BITS;
   localparam logic [DEC_LINES-1:0] BASE_L = DEC_LINES'(BASE);

   logic low_hit;

   if (BASE % (1 << WIN_BITS) != 0) begin : g_chk_align
      $error("window base must be aligned to the window size");
   end
   if (!in_card_space(BASE, WIN_BITS)) begin : g_chk_space
      $error("window must lie in the add-on card range 200h..3FFh");
   end
   if (BANKED && ADDR_W <= UP_LO) begin : g_chk_width
      $error("address too narrow for banked decode");
   end

   assign low_hit = (addr[DEC_LINES-1:WIN_BITS] == BASE_L[DEC_LINES-1:WIN_BITS]);
   assign off     = addr[WIN_BITS-1:0];

   if (BANKED) begin : g_banked
      assign bank = addr[UP_LO-1:DEC_LINES];
      assign hit  = low_hit && (addr[ADDR_W-1:UP_LO] == '0);
   end else begin : g_flat
      assign bank = '0;
      assign hit  = low_hit;
   end
endmodule

// File: rtl/iodec_index.sv
module iodec_index #(
   parameter int unsigned IDX_W = 3,
   localparam int unsigned NREG = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [IDX_W-1:0] din,
   input  logic             dat_rd,
   input  logic             dat_wr,
   output logic [IDX_W-1:0] idx_q,
   output logic [NREG-1:0]  reg_rd,
   output logic [NREG-1:0]  reg_wr
);
   if (IDX_W < 1 || IDX_W > 6) begin : g_chk_idx
      $error("index width out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q <= '0;
      else if (ld) idx_q <= din;
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      assign reg_rd[r] = dat_rd && (idx_q == IDX_W'(r));
      assign reg_wr[r] = dat_wr && (idx_q == IDX_W'(r));
   end

   assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(idx_q));
   assert_reg_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({reg_rd, reg_wr}));
   assert_reg_needs_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd != '0) |-> dat_rd);
endmodule

// File: rtl/legacy_io_decoder.sv
module legacy_io_decoder
   import iodec_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned BASE      = 32'h300,
   parameter int unsigned WIN_BITS  = 5,
   parameter int unsigned BANK_BITS = 4,
   parameter bit          BANKED    = 1'b1,
   parameter int unsigned IDX_W     = 3,
   parameter int unsigned IDX_BANK  = 0,
   parameter int unsigned IDX_OFF   = 0,
   parameter int unsigned DAT_OFF   = 1,
   localparam int unsigned NBANK    = 1 << BANK_BITS,
   localparam int unsigned NREG     = 1 << IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 aen,
   input  logic                 ior_n,
   input  logic                 iow_n,
   input  logic [IDX_W-1:0]     idx_wdata,
   output logic [NBANK-1:0]     bank_sel,
   output logic [WIN_BITS-1:0]  port_off,
   output logic                 rd_stb,
   output logic                 wr_stb,
   output logic                 idx_oe,
   output logic [IDX_W-1:0]     idx_q,
   output logic [NREG-1:0]      reg_rd,
   output logic [NREG-1:0]      reg_wr
);
   if (IDX_BANK >= NBANK || IDX_OFF == DAT_OFF ||
       IDX_OFF >= (1 << WIN_BITS) || DAT_OFF >= (1 << WIN_BITS)) begin : g_chk_pair
      $error("index/data pair placement invalid");
   end

   iodec_cyc_t           cyc;
   logic                 hit;
   logic [BANK_BITS-1:0] bank;
   logic                 pair_bank;
   logic                 at_idx;
   logic                 at_dat;

   iodec_cycle_qual u_qual (
      .aen   (aen),
      .ior_n (ior_n),
      .iow_n (iow_n),
      .cyc   (cyc)
   );

   iodec_window #(
      .ADDR_W    (ADDR_W),
      .BASE      (BASE),
      .WIN_BITS  (WIN_BITS),
      .BANK_BITS (BANK_BITS),
      .BANKED    (BANKED)
   ) u_win (
      .addr (addr),
      .hit  (hit),
      .bank (bank),
      .off  (port_off)
   );

   assign rd_stb    = cyc.rd && hit;
   assign wr_stb    = cyc.wr && hit;
   assign pair_bank = (bank == BANK_BITS'(IDX_BANK));
   assign at_idx    = pair_bank && (port_off == WIN_BITS'(IDX_OFF));
   assign at_dat    = pair_bank && (port_off == WIN_BITS'(DAT_OFF));
   assign idx_oe    = rd_stb && at_idx;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign bank_sel[b] = (rd_stb || wr_stb) && (bank == BANK_BITS'(b));
   end

   iodec_index #(.IDX_W(IDX_W)) u_idx (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (wr_stb && at_idx),
      .din    (idx_wdata),
      .dat_rd (rd_stb && at_dat),
      .dat_wr (wr_stb && at_dat),
      .idx_q  (idx_q),
      .reg_rd (reg_rd),
      .reg_wr (reg_wr)
   );

   assert_aen_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
      aen |-> !rd_stb && !wr_stb && (bank_sel == '0));
   assert_rd_needs_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |-> !ior_n && iow_n);
   assert_bank_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_sel));
   assert_both_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ior_n && !iow_n) |-> !rd_stb && !wr_stb);
   assert_oe_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      idx_oe |-> rd_stb && !wr_stb);
endmodule

// File: tb/sim_legacy_io_decoder.sv
module sim_legacy_io_decoder;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic        aen = 1'b0;
   logic        ior_n = 1'b1;
   logic        iow_n = 1'b1;
   logic [2:0]  idx_wdata = '0;
   logic [15:0] bank_sel;
   logic [4:0]  port_off;
   logic        rd_stb, wr_stb, idx_oe;
   logic [2:0]  idx_q;
   logic [7:0]  reg_rd, reg_wr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   legacy_io_decoder u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .aen(aen), .ior_n(ior_n), .iow_n(iow_n),
      .idx_wdata(idx_wdata), .bank_sel(bank_sel), .port_off(port_off), .rd_stb(rd_stb),
      .wr_stb(wr_stb), .idx_oe(idx_oe), .idx_q(idx_q), .reg_rd(reg_rd), .reg_wr(reg_wr)
   );

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s addr=%h got=%h exp=%h", req, addr, got, exp);
      end
   endtask

   function automatic logic [42:0] expect_outs(input logic [15:0] a, input logic e,
                                               input logic r_n, input logic w_n,
                                               input logic [2:0] ix);
      logic hit, rd, wr;
      logic [15:0] bs;
      logic [7:0] rr, rw;
      logic oe;
      hit = (a[9:5] == 5'b11000) && (a[15:14] == 2'b00);
      rd  = hit && !e && !r_n && w_n;
      wr  = hit && !e && !w_n && r_n;
      bs  = (rd || wr) ? (16'd1 << a[13:10]) : 16'd0;
      oe  = rd && a[13:10] == 4'd0 && a[4:0] == 5'd0;
      rr  = (rd && a[13:10] == 4'd0 && a[4:0] == 5'd1) ? (8'd1 << ix) : 8'd0;
      rw  = (wr && a[13:10] == 4'd0 && a[4:0] == 5'd1) ? (8'd1 << ix) : 8'd0;
      return {bs, rd, wr, oe, rr, rw, a[4:0], ix};
   endfunction

   function automatic logic [42:0] actual_outs();
      return {bank_sel, rd_stb, wr_stb, idx_oe, reg_rd, reg_wr, port_off, idx_q};
   endfunction

   task automatic write_idx(input logic [15:0] a, input logic [2:0] v, input logic e);
      @(negedge clk);
      addr = a; idx_wdata = v; aen = e; iow_n = 1'b0; ior_n = 1'b1;
      @(negedge clk);
      iow_n = 1'b1; aen = 1'b0;
      #1;
   endtask

   task automatic read_idx(input logic [2:0] exp);
      @(negedge clk);
      addr = 16'h0300; ior_n = 1'b0; iow_n = 1'b1; aen = 1'b0;
      #1;
      check("R7 idx read", {61'd0, idx_oe, rd_stb, bank_sel[0]}, 64'h7);
      check("R6 idx value", {61'd0, idx_q}, {61'd0, exp});
      ior_n = 1'b1;
      #1;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R5 reset idx", {61'd0, idx_q}, 64'd0);
      check("R1 idle strobes", {45'd0, bank_sel, rd_stb, wr_stb, idx_oe}, 64'd0);
      rst_n = 1'b1;

      // R6 R7 R8: every index value via the data port
      for (int v = 0; v < 8; v++) begin
         write_idx(16'h0300, 3'(v), 1'b0);
         read_idx(3'(v));
         addr = 16'h0301; ior_n = 1'b0; #1;
         check("R8 reg_rd onehot", {56'd0, reg_rd}, 64'd1 << v);
         ior_n = 1'b1; iow_n = 1'b0; #1;
         check("R8 reg_wr onehot", {56'd0, reg_wr}, 64'd1 << v);
         iow_n = 1'b1; #1;
      end

      // R6 ignored writes: aliased bank, aen high, data port, outside window
      write_idx(16'h0300, 3'd2, 1'b0);
      write_idx(16'h0700, 3'd6, 1'b0);
      read_idx(3'd2);
      write_idx(16'h0300, 3'd6, 1'b1);
      read_idx(3'd2);
      write_idx(16'h0301, 3'd6, 1'b0);
      read_idx(3'd2);
      write_idx(16'h4300, 3'd6, 1'b0);
      read_idx(3'd2);

      // R5 reset again clears index
      write_idx(16'h0300, 3'd7, 1'b0);
      rst_n = 1'b0; #1;
      check("R5 async reset idx", {61'd0, idx_q}, 64'd0);
      @(negedge clk); rst_n = 1'b1;

      // full sweep with index held at 5
      write_idx(16'h0300, 3'd5, 1'b0);
      idx_wdata = 3'd5;
      for (int a = 0; a < 65536; a++) begin
         for (int op = 0; op < 2; op++) begin
            addr = 16'(a); aen = 1'b0;
            ior_n = (op == 0) ? 1'b0 : 1'b1;
            iow_n = (op == 0) ? 1'b1 : 1'b0;
            #1;
            check("R1 R2 R3 R7 R8 sweep", {21'd0, actual_outs()},
                  {21'd0, expect_outs(16'(a), 1'b0, ior_n, iow_n, 3'd5)});
         end
      end

      // R1 aen high and R4 both strobes low
      for (int a = 0; a < 65536; a += 37) begin
         addr = 16'(a);
         aen = 1'b1; ior_n = 1'b0; iow_n = 1'b1; #1;
         check("R1 aen blocks rd", {21'd0, actual_outs()},
               {21'd0, expect_outs(16'(a), 1'b1, 1'b0, 1'b1, 3'd5)});
         iow_n = 1'b0; ior_n = 1'b1; #1;
         check("R1 aen blocks wr", {21'd0, actual_outs()},
               {21'd0, expect_outs(16'(a), 1'b1, 1'b1, 1'b0, 3'd5)});
         aen = 1'b0; ior_n = 1'b0; iow_n = 1'b0; #1;
         check("R4 both strobes", {21'd0, actual_outs()},
               {21'd0, expect_outs(16'(a), 1'b0, 1'b0, 1'b0, 3'd5)});
      end
      for (int o = 0; o < 32; o++) begin
         addr = 16'h0300 + 16'(o); aen = 1'b0; ior_n = 1'b0; iow_n = 1'b0; #1;
         check("R4 both strobes in window", {45'd0, bank_sel, rd_stb, wr_stb, idx_oe}, 64'd0);
      end
      ior_n = 1'b1; iow_n = 1'b1;
      read_idx(3'd5);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule